// File: doc/BRIEF.md
# Bitwise and Shift Execution Unit

This unit carries out the bitwise and shift group of an accumulator-style processor. It covers the logic operations AND, OR and XOR, shift left and shift right, rotate left and rotate right through carry, two bit-test forms, and two read-modify-write forms that clear or set memory bits under an accumulator mask. Each operation also updates the status flags.

The decoder presents one operation with `in_valid`. It also presents the accumulator, the operand fetched for the operation, the current flags and a target selector. For a shift or rotate on the accumulator, the decoder presents the accumulator value as the operand. One clock later the unit presents the new accumulator, any memory write-back value with its strobe, and the updated flags, all from registers.

The flags travel as a 4-bit vector: bit 3 = N (negative), bit 2 = V (overflow), bit 1 = Z (zero), bit 0 = C (carry). The operation codes are: 0 AND, 1 OR, 2 XOR, 3 shift left, 4 shift right, 5 rotate left, 6 rotate right, 7 bit test, 8 immediate bit test, 9 test-and-clear, 10 test-and-set. Codes 11 to 15 are unassigned.

Top module: `bitshift_unit`

## Requirements
- R1: For AND (0), OR (1) and XOR (2), the result of accumulator and operand is written to the accumulator with `acc_we`. N equals result bit 7 and Z is set when the result is zero.
- R2: Shift left (3) produces operand << 1. C takes operand bit 7. N and Z follow the result.
- R3: Shift right (4) produces operand >> 1 with zero in bit 7. N is always cleared, C takes operand bit 0, and Z follows the result.
- R4: Rotate left (5) puts the incoming C into bit 0 and operand bit 7 into C. Rotate right (6) puts the incoming C into bit 7 and operand bit 0 into C. N and Z follow the result.
- R5: A shift or rotate with `tgt_mem`=0 writes the accumulator (`acc_we`). With `tgt_mem`=1 it writes `mem_out` with `mem_we`, and the accumulator keeps its value.
- R6: Bit test (7) sets Z when (accumulator & operand) is zero, copies operand bit 7 into N and operand bit 6 into V. It raises no strobe and leaves the accumulator unchanged.
- R7: Immediate bit test (8) updates only Z, using the same rule as R6. N, V and C keep their incoming values.
- R8: Test-and-clear (9) sets Z as in R6 and writes (~accumulator & operand) to memory with `mem_we`.
- R9: Test-and-set (10) sets Z as in R6 and writes (accumulator | operand) to memory with `mem_we`.
- R10: A flag that an operation does not name keeps its incoming value. This covers V for every operation except bit test, and C for the logic and bit-test operations.
- R11: Outputs appear one clock after `in_valid`. The strobes are high for that single cycle only. Without `in_valid`, no strobe rises, and the accumulator and flag outputs hold.
- R12: Synchronous active-high reset clears the accumulator output, the memory value, all flags and both strobes.
- R13: Unassigned codes (11 to 15) raise no strobe. They pass the incoming accumulator and flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | DATA_W | Current accumulator |
| opnd_in | input | DATA_W | Operand (the accumulator itself for shifts on the accumulator) |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| tgt_mem | input | 1 | 1: shift result goes to memory; 0: to the accumulator |
| acc_out | output | DATA_W | Registered new accumulator |
| acc_we | output | 1 | Accumulator write strobe |
| mem_out | output | DATA_W | Registered memory write-back value |
| mem_we | output | 1 | Memory write strobe |
| flags_out | output | 4 | Registered new flags {N,V,Z,C} |

## Verification
The bench builds the unit at its default `DATA_W` of 8. At that width the sign bit and the overflow source bit of the bit test land on bits 7 and 6. This lets each operand be chosen so that exactly the bit entering or leaving through carry is set or clear. The patterns drive carry into and out of both ends of the rotates, produce zero results from shifts and from XOR, and use masks that clear or set every memory bit. These cases expose mix-ups between which flag is held and which is replaced.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   localparam int OP_W   = 4;
   localparam int FLAG_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_AND  = 4'd0,
      OP_OR   = 4'd1,
      OP_XOR  = 4'd2,
      OP_SHL  = 4'd3,
      OP_SHR  = 4'd4,
      OP_ROL  = 4'd5,
      OP_ROR  = 4'd6,
      OP_TST  = 4'd7,
      OP_TSTI = 4'd8,
      OP_CLRB = 4'd9,
      OP_SETB = 4'd10
   } bsu_op_e;

   // Packed order matches the flag vector: n is bit 3, c is bit 0.
   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } bsu_flags_t;

   function automatic logic is_shift(input logic [OP_W-1:0] op);
      return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
   endfunction

endpackage

// File: rtl/bsu_logic.sv
// Bitwise stage: the two-operand logic results plus the masked-memory results.
module bsu_logic import bsu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] m,
   output logic [DATA_W-1:0] logic_res,
   output logic [DATA_W-1:0] clr_res,
   output logic [DATA_W-1:0] set_res,
   output logic              mask_zero
);

   logic [DATA_W-1:0] and_v;
   logic [DATA_W-1:0] or_v;
   logic [DATA_W-1:0] xor_v;

   assign and_v     = a & m;
   assign or_v      = a | m;
   assign xor_v     = a ^ m;
   assign clr_res   = ~a & m;
   assign set_res   = or_v;
   assign mask_zero = (and_v == '0);

   always_comb begin
      unique case (op)
         OP_OR:   logic_res = or_v;
         OP_XOR:  logic_res = xor_v;
         default: logic_res = and_v;
      endcase
   end

endmodule

// File: rtl/bsu_shift.sv
// Shift / rotate stage. Both directions are built lane by lane; the
// rotates share the same lanes with the carry as the fill bit.
module bsu_shift import bsu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] m,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   localparam int MSB = DATA_W - 1;

   logic go_left;
   logic rotate;
   logic fill;
   logic [DATA_W-1:0] left_v;
   logic [DATA_W-1:0] right_v;

   assign go_left = (op == OP_SHL) || (op == OP_ROL);
   assign rotate  = (op == OP_ROL) || (op == OP_ROR);
   assign fill    = rotate & cin;

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i == 0) begin : g_lo
         assign left_v[i]  = fill;
         assign right_v[i] = m[i+1];
      end else if (i == MSB) begin : g_hi
         assign left_v[i]  = m[i-1];
         assign right_v[i] = fill;
      end else begin : g_mid
         assign left_v[i]  = m[i-1];
         assign right_v[i] = m[i+1];
      end
   end

   assign res  = go_left ? left_v : right_v;
   assign cout = go_left ? m[MSB] : m[0];

endmodule

// File: rtl/bsu_select.sv
// Result routing and flag merge: picks the destination and which flags change.
module bsu_select import bsu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic              tgt_mem,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] m,
   input  bsu_flags_t        fin,
   input  logic [DATA_W-1:0] logic_res,
   input  logic [DATA_W-1:0] clr_res,
   input  logic [DATA_W-1:0] set_res,
   input  logic              mask_zero,
   input  logic [DATA_W-1:0] shift_res,
   input  logic              shift_cout,
   output logic [DATA_W-1:0] nxt_acc,
   output logic              nxt_acc_we,
   output logic [DATA_W-1:0] nxt_mem,
   output logic              nxt_mem_we,
   output bsu_flags_t        nxt_flags
);

   localparam int SIGN_B = DATA_W - 1;
   localparam int OVF_B  = DATA_W - 2;

   always_comb begin
      nxt_acc    = a;
      nxt_acc_we = 1'b0;
      nxt_mem    = m;
      nxt_mem_we = 1'b0;
      nxt_flags  = fin;
      case (op)
         OP_AND, OP_OR, OP_XOR: begin
            nxt_acc     = logic_res;
            nxt_acc_we  = 1'b1;
            nxt_flags.n = logic_res[SIGN_B];
            nxt_flags.z = (logic_res == '0);
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            nxt_flags.c = shift_cout;
            nxt_flags.z = (shift_res == '0);
            nxt_flags.n = (op == OP_SHR) ? 1'b0 : shift_res[SIGN_B];
            if (tgt_mem) begin
               nxt_mem    = shift_res;
               nxt_mem_we = 1'b1;
            end else begin
               nxt_acc    = shift_res;
               nxt_acc_we = 1'b1;
            end
         end
         OP_TST: begin
            nxt_flags.z = mask_zero;
            nxt_flags.n = m[SIGN_B];
            nxt_flags.v = m[OVF_B];
         end
         OP_TSTI: begin
            nxt_flags.z = mask_zero;
         end
         OP_CLRB: begin
            nxt_flags.z = mask_zero;
            nxt_mem     = clr_res;
            nxt_mem_we  = 1'b1;
         end
         OP_SETB: begin
            nxt_flags.z = mask_zero;
            nxt_mem     = set_res;
            nxt_mem_we  = 1'b1;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit import bsu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic [3:0]        flags_in,
   input  logic              tgt_mem,
   output logic [DATA_W-1:0] acc_out,
   output logic              acc_we,
   output logic [DATA_W-1:0] mem_out,
   output logic              mem_we,
   output logic [3:0]        flags_out
);

   if (DATA_W < 3) begin : g_bad_width
      $error("bitshift_unit: DATA_W must be at least 3");
   end
   if (FLAG_W != 4) begin : g_bad_flags
      $error("bitshift_unit: flag vector must be four bits");
   end

   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] clr_res;
   logic [DATA_W-1:0] set_res;
   logic              mask_zero;
   logic [DATA_W-1:0] shift_res;
   logic              shift_cout;
   logic [DATA_W-1:0] nxt_acc;
   logic              nxt_acc_we;
   logic [DATA_W-1:0] nxt_mem;
   logic              nxt_mem_we;
   bsu_flags_t        fin;
   bsu_flags_t        nxt_flags;

   assign fin = bsu_flags_t'(flags_in);

   bsu_logic #(.DATA_W(DATA_W)) u_logic (
      .op        (op_sel),
      .a         (acc_in),
      .m         (opnd_in),
      .logic_res (logic_res),
      .clr_res   (clr_res),
      .set_res   (set_res),
      .mask_zero (mask_zero)
   );

   bsu_shift #(.DATA_W(DATA_W)) u_shift (
      .op   (op_sel),
      .m    (opnd_in),
      .cin  (fin.c),
      .res  (shift_res),
      .cout (shift_cout)
   );

   bsu_select #(.DATA_W(DATA_W)) u_select (
      .op         (op_sel),
      .tgt_mem    (tgt_mem),
      .a          (acc_in),
      .m          (opnd_in),
      .fin        (fin),
      .logic_res  (logic_res),
      .clr_res    (clr_res),
      .set_res    (set_res),
      .mask_zero  (mask_zero),
      .shift_res  (shift_res),
      .shift_cout (shift_cout),
      .nxt_acc    (nxt_acc),
      .nxt_acc_we (nxt_acc_we),
      .nxt_mem    (nxt_mem),
      .nxt_mem_we (nxt_mem_we),
      .nxt_flags  (nxt_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_out   <= '0;
         mem_out   <= '0;
         flags_out <= '0;
         acc_we    <= 1'b0;
         mem_we    <= 1'b0;
      end else if (in_valid) begin
         acc_out   <= nxt_acc;
         mem_out   <= nxt_mem;
         flags_out <= nxt_flags;
         acc_we    <= nxt_acc_we;
         mem_we    <= nxt_mem_we;
      end else begin
         acc_we    <= 1'b0;
         mem_we    <= 1'b0;
      end
   end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker import bsu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [OP_W-1:0]   op_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] opnd_in,
   input logic [3:0]        flags_in,
   input logic              tgt_mem,
   input logic [DATA_W-1:0] acc_out,
   input logic              acc_we,
   input logic [DATA_W-1:0] mem_out,
   input logic              mem_we,
   input logic [3:0]        flags_out
);

   p_reset_clear_r12: assert property (@(posedge clk)
      $past(rst) |-> (acc_out == '0 && flags_out == '0 && !acc_we && !mem_we));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !$past(in_valid) |-> (!acc_we && !mem_we));

   p_one_target_r5: assert property (@(posedge clk) disable iff (rst)
      !(acc_we && mem_we));

   p_shr_neg_clear_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && $past(op_sel) == OP_SHR) |-> !flags_out[3]);

   p_test_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && $past(op_sel) == OP_TST)
      |-> (!acc_we && !mem_we && acc_out == $past(acc_in)));

   p_v_held_r10: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && $past(op_sel) != OP_TST) |-> (flags_out[2] == $past(flags_in[2])));

   p_mask_zero_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && ($past(op_sel) == OP_CLRB || $past(op_sel) == OP_SETB
                           || $past(op_sel) == OP_TSTI))
      |-> (flags_out[1] == (($past(acc_in) & $past(opnd_in)) == '0)));

   p_mem_target_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && is_shift($past(op_sel)) && $past(tgt_mem))
      |-> (mem_we && acc_out == $past(acc_in)));

   p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !$past(in_valid) |-> $stable(mem_out));

endmodule

bind bitshift_unit bsu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .acc_in    (acc_in),
   .opnd_in   (opnd_in),
   .flags_in  (flags_in),
   .tgt_mem   (tgt_mem),
   .acc_out   (acc_out),
   .acc_we    (acc_we),
   .mem_out   (mem_out),
   .mem_we    (mem_we),
   .flags_out (flags_out)
);

// File: tb/sim_bitshift_unit.sv
module sim_bitshift_unit;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [3:0]   op_sel;
   logic [W-1:0] acc_in;
   logic [W-1:0] opnd_in;
   logic [3:0]   flags_in;
   logic         tgt_mem;
   logic [W-1:0] acc_out;
   logic         acc_we;
   logic [W-1:0] mem_out;
   logic         mem_we;
   logic [3:0]   flags_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   bitshift_unit #(.DATA_W(W)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
      .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in), .tgt_mem(tgt_mem),
      .acc_out(acc_out), .acc_we(acc_we), .mem_out(mem_out), .mem_we(mem_we),
      .flags_out(flags_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Present one operation for one cycle; return at the following negedge.
   task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] m,
                        input logic [3:0] f, input logic tm);
      @(negedge clk);
      op_sel = op; acc_in = a; opnd_in = m; flags_in = f; tgt_mem = tm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_acc(input string tag, input logic [W-1:0] ea, input logic [3:0] ef);
      chk({tag, " acc"}, acc_out, ea);
      chk({tag, " acc_we"}, acc_we, 1'b1);
      chk({tag, " mem_we"}, mem_we, 1'b0);
      chk({tag, " flags"}, flags_out, ef);
   endtask

   task automatic expect_mem(input string tag, input logic [W-1:0] ea, input logic [W-1:0] em,
                             input logic [3:0] ef);
      chk({tag, " acc"}, acc_out, ea);
      chk({tag, " acc_we"}, acc_we, 1'b0);
      chk({tag, " mem"}, mem_out, em);
      chk({tag, " mem_we"}, mem_we, 1'b1);
      chk({tag, " flags"}, flags_out, ef);
   endtask

   task automatic expect_none(input string tag, input logic [W-1:0] ea, input logic [3:0] ef);
      chk({tag, " acc"}, acc_out, ea);
      chk({tag, " acc_we"}, acc_we, 1'b0);
      chk({tag, " mem_we"}, mem_we, 1'b0);
      chk({tag, " flags"}, flags_out, ef);
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; op_sel = '0; acc_in = 8'hAA; opnd_in = 8'h55;
      flags_in = 4'hF; tgt_mem = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 acc", acc_out, 8'h00);
      chk("R12 mem", mem_out, 8'h00);
      chk("R12 flags", flags_out, 4'h0);
      chk("R12 strobes", {acc_we, mem_we}, 2'b00);
      rst = 1'b0;
   endtask

   task automatic t_logic();
      apply(4'd0, 8'hF0, 8'h3C, 4'b0101, 1'b0);
      expect_acc("R1 and / R10", 8'h30, 4'b0101);
      apply(4'd1, 8'h80, 8'h01, 4'b0000, 1'b0);
      expect_acc("R1 or", 8'h81, 4'b1000);
      apply(4'd2, 8'h5A, 8'h5A, 4'b1001, 1'b0);
      expect_acc("R1 xor zero / R10", 8'h00, 4'b0011);
   endtask

   task automatic t_shl();
      apply(4'd3, 8'h00, 8'hC1, 4'b0000, 1'b0);
      expect_acc("R2 shl", 8'h82, 4'b1001);
      apply(4'd3, 8'h00, 8'h80, 4'b0100, 1'b0);
      expect_acc("R2 shl zero", 8'h00, 4'b0111);
   endtask

   task automatic t_shr();
      apply(4'd4, 8'h00, 8'h01, 4'b1000, 1'b0);
      expect_acc("R3 shr zero", 8'h00, 4'b0011);
      apply(4'd4, 8'h00, 8'hFE, 4'b0001, 1'b0);
      expect_acc("R3 shr", 8'h7F, 4'b0000);
   endtask

   task automatic t_rotate();
      apply(4'd5, 8'h00, 8'h80, 4'b0001, 1'b0);
      expect_acc("R4 rol carry", 8'h01, 4'b0001);
      apply(4'd5, 8'h00, 8'h40, 4'b0000, 1'b0);
      expect_acc("R4 rol", 8'h80, 4'b1000);
      apply(4'd6, 8'h00, 8'h01, 4'b0000, 1'b0);
      expect_acc("R4 ror zero", 8'h00, 4'b0011);
      apply(4'd6, 8'h00, 8'h02, 4'b0001, 1'b0);
      expect_acc("R4 ror carry", 8'h81, 4'b1000);
   endtask

   task automatic t_target();
      apply(4'd3, 8'h11, 8'h03, 4'b0000, 1'b1);
      expect_mem("R5 shl mem", 8'h11, 8'h06, 4'b0000);
      apply(4'd6, 8'h22, 8'h01, 4'b0001, 1'b1);
      expect_mem("R5 ror mem", 8'h22, 8'h80, 4'b1001);
   endtask

   task automatic t_bit();
      apply(4'd7, 8'h0F, 8'hC0, 4'b0001, 1'b0);
      expect_none("R6 test set", 8'h0F, 4'b1111);
      apply(4'd7, 8'h01, 8'h01, 4'b1100, 1'b0);
      expect_none("R6 test clear", 8'h01, 4'b0000);
   endtask

   task automatic t_bit_imm();
      apply(4'd8, 8'h0F, 8'hC0, 4'b0000, 1'b0);
      expect_none("R7 imm zero", 8'h0F, 4'b0010);
      apply(4'd8, 8'h01, 8'h03, 4'b1111, 1'b0);
      expect_none("R7 imm hit", 8'h01, 4'b1101);
   endtask

   task automatic t_clear_set();
      apply(4'd9, 8'h59, 8'hFF, 4'b0010, 1'b0);
      expect_mem("R8 clear bits", 8'h59, 8'hA6, 4'b0000);
      apply(4'd10, 8'h0F, 8'hF0, 4'b1101, 1'b0);
      expect_mem("R9 set bits", 8'h0F, 8'hFF, 4'b1111);
   endtask

   task automatic t_idle();
      apply(4'd1, 8'h10, 8'h02, 4'b0000, 1'b0);
      expect_acc("R11 setup", 8'h12, 4'b0000);
      op_sel = 4'd2; acc_in = 8'hFF; opnd_in = 8'h0F; flags_in = 4'hF; tgt_mem = 1'b1;
      @(negedge clk);
      expect_none("R11 idle 1", 8'h12, 4'b0000);
      @(negedge clk);
      expect_none("R11 idle 2", 8'h12, 4'b0000);
   endtask

   task automatic t_unused();
      for (int code = 11; code < 16; code++) begin
         apply(4'(code), 8'h33, 8'hC3, 4'b1010, 1'b1);
         expect_none("R13 unassigned", 8'h33, 4'b1010);
      end
   endtask

   initial begin
      t_reset();
      t_logic();
      t_shl();
      t_shr();
      t_rotate();
      t_target();
      t_bit();
      t_bit_imm();
      t_clear_set();
      t_idle();
      t_unused();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule